// File: doc/BRIEF.md
# Baud Sample Tick Generator

This block turns a free-running reference clock into the timing enables used by a serial framing engine. The reference clock can first pass through an optional small prescaler. It then goes through a 16-bit integer divider. The divider's output is a one-cycle sample tick: a clock enable in the reference domain, not a derived clock. A second stage counts sample ticks and raises a bit strobe once every 4, 8 or 16 ticks, as set by the selected oversampling factor. The receiver and transmitter use that strobe as their bit-rate event.

The three settings (divisor, prescaler, oversampling factor) are read only when the stage that uses them reloads. Software can therefore rewrite them at any time without shortening or stretching the interval already in progress. With the prescaler bypassed, a divisor of 1 and a factor of 4, the bit strobe runs at one quarter of the reference clock. For example, a 16.5 MHz reference gives 4.125 Mbaud.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, `sample_tick` and `bit_strobe` are 0. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R2: With the prescaler off, `sample_tick` is high for exactly one `clk_ref` cycle every D cycles, where D is the `divisor` value (1 to 65535).
- R3: A `divisor` value of 0 behaves as 1, so a tick occurs on every cycle.
- R4: With `pre_en` = 1, the tick interval is P × D cycles, where P is `pre_val` (1 to 15). A `pre_val` of 0 behaves as 1.
- R5: With `pre_en` = 0, `pre_val` has no effect and the tick interval is D.
- R6: `bit_strobe` is high only in a cycle where `sample_tick` is high. It fires once every F sample ticks, with F encoded by `sample_sel`: 2'b00 = 16, 2'b01 = 8, 2'b10 = 4, 2'b11 = 16.
- R7: A change to `divisor`, `pre_val` or `sample_sel` takes effect only when the affected counter reloads. The interval in progress completes with its old length, so no runt or stretched tick occurs.
- R8: With D = 1, F = 4 and the prescaler off, `bit_strobe` fires every 4 cycles. No two bit strobes are ever closer than 4 cycles apart.
- R9: After reset release, the first `sample_tick` and the first `bit_strobe` rise together, on the third `clk_ref` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Integer divide value; 0 is treated as 1 |
| pre_en | input | 1 | Enables the prescaler stage |
| pre_val | input | 4 | Prescaler divide value; 0 is treated as 1 |
| sample_sel | input | 2 | Oversampling factor select (00/11 = 16, 01 = 8, 10 = 4) |
| sample_tick | output | 1 | One-cycle sample enable |
| bit_strobe | output | 1 | One-cycle bit-rate enable, aligned with a sample tick |

## Verification
Two functions can fall in the same cycle: a counter reload, and a write of a new divisor or factor arriving in that reload cycle or just before it. The bench provokes this by changing settings at random cycles, with no regard to counter phase, while a cycle-exact model built from the reload rule predicts both outputs on every cycle. A directed case rewrites the divisor a few cycles into a long interval. It then checks that the interval still ends at its old length and that the next interval uses the new value. Coincident tick and strobe events are judged by the assertion that a bit strobe never appears without a sample tick.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Encoding of the oversampling factor select
  typedef enum logic [1:0] {
    OVS_X16  = 2'b00,
    OVS_X8   = 2'b01,
    OVS_X4   = 2'b10,
    OVS_X16B = 2'b11
  } ovs_sel_e;

  localparam int unsigned OVS_W = 5;

endpackage

// File: rtl/tick_divider.sv
// Reloading down-counter: fires on the step in which the count is 1 (or 0),
// then reloads from the limit sampled at that moment.
module tick_divider #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         fire
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] eff_limit;

  always_comb begin
    eff_limit = (limit == '0) ? W'(1) : limit;
    fire      = step && (cnt_q <= W'(1));
    cnt_d     = cnt_q;
    if (step) begin
      if (fire) cnt_d = eff_limit;
      else      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ovs_decode.sv
module ovs_decode
  import baud_tick_pkg::*;
(
  input  logic [1:0]       sel,
  output logic [OVS_W-1:0] factor
);

  ovs_sel_e sel_e;

  always_comb begin
    sel_e = ovs_sel_e'(sel);
    unique case (sel_e)
      OVS_X8:  factor = OVS_W'(8);
      OVS_X4:  factor = OVS_W'(4);
      default: factor = OVS_W'(16);
    endcase
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned PRE_W   = 4,
  parameter bit          HAS_PRE = 1'b1
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [1:0]       sample_sel,
  output logic             sample_tick,
  output logic             bit_strobe
);

  localparam int unsigned SYNC_STAGES = 2;

  // Reset synchronizer: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic [SYNC_STAGES-1:0] rst_sync_d;
  logic                   rst_int_n;

  always_comb rst_sync_d = {rst_sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // Prescaler stage (optional in hardware)
  logic pre_fire;
  logic div_step;

  generate
    if (HAS_PRE) begin : g_pre
      tick_divider #(.W(PRE_W)) u_pre (
        .clk   (clk_ref),
        .rst_n (rst_int_n),
        .step  (pre_en),
        .limit (pre_val),
        .fire  (pre_fire)
      );
      always_comb div_step = pre_en ? pre_fire : 1'b1;
    end else begin : g_nopre
      always_comb pre_fire = 1'b0;
      always_comb div_step = 1'b1;
    end
  endgenerate

  // Main divisor stage
  logic div_fire;

  tick_divider #(.W(DIV_W)) u_div (
    .clk   (clk_ref),
    .rst_n (rst_int_n),
    .step  (div_step),
    .limit (divisor),
    .fire  (div_fire)
  );

  // Oversampling stage
  logic [OVS_W-1:0] factor;
  logic             bit_fire;

  ovs_decode u_dec (
    .sel    (sample_sel),
    .factor (factor)
  );

  tick_divider #(.W(OVS_W)) u_bit (
    .clk   (clk_ref),
    .rst_n (rst_int_n),
    .step  (div_fire),
    .limit (factor),
    .fire  (bit_fire)
  );

  // Registered outputs
  logic tick_q, tick_d;
  logic bit_q, bit_d;

  always_comb begin
    tick_d = div_fire;
    bit_d  = bit_fire;
  end

  always_ff @(posedge clk_ref or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      bit_q  <= bit_d;
    end
  end

  assign sample_tick = tick_q;
  assign bit_strobe  = bit_q;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned PRE_W = 4
) (
  input logic clk_ref,
  input logic rst_n,
  input logic sample_tick,
  input logic bit_strobe
);

  localparam longint unsigned MAX_GAP =
    ((64'd1 << DIV_W) - 1) * ((64'd1 << PRE_W) - 1) + 64'd4;

  logic [31:0] since_tick;
  logic [31:0] since_bit;
  logic        seen_bit;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      since_tick <= 32'd0;
      since_bit  <= 32'd0;
      seen_bit   <= 1'b0;
    end else begin
      if (sample_tick)              since_tick <= 32'd1;
      else if (since_tick != '1)    since_tick <= since_tick + 32'd1;
      if (bit_strobe) begin
        since_bit <= 32'd1;
        seen_bit  <= 1'b1;
      end else if (since_bit != '1) begin
        since_bit <= since_bit + 32'd1;
      end
    end
  end

  // R1: quiet outputs while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk_ref)
    !rst_n |-> (!sample_tick && !bit_strobe));

  // R6: a bit strobe always rides on a sample tick
  a_r6_bit_on_tick: assert property (@(posedge clk_ref) disable iff (!rst_n)
    bit_strobe |-> sample_tick);

  // R8: bit strobes at least four cycles apart
  a_r8_bit_gap_min: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (bit_strobe && seen_bit) |-> (since_bit >= 32'd4));

  // R2: ticks never stop for longer than the largest programmable interval
  a_r2_tick_gap_max: assert property (@(posedge clk_ref) disable iff (!rst_n)
    64'(since_tick) <= MAX_GAP);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_chk (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .sample_tick (sample_tick),
  .bit_strobe  (bit_strobe)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic [15:0] divisor;
  logic        pre_en;
  logic [3:0]  pre_val;
  logic [1:0]  sample_sel;
  logic        sample_tick, bit_strobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  baud_tick_gen uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .divisor(divisor), .pre_en(pre_en),
    .pre_val(pre_val), .sample_sel(sample_sel),
    .sample_tick(sample_tick), .bit_strobe(bit_strobe)
  );

  function automatic int eff16(input logic [15:0] v);
    return (v == 16'd0) ? 1 : int'(v);
  endfunction
  function automatic int eff4(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction
  function automatic int ovs(input logic [1:0] s);
    return (s == 2'b10) ? 4 : (s == 2'b01) ? 8 : 16;
  endfunction

  // Cycle-exact reference built from the reload rule (R7)
  logic m_r1, m_r2, m_tick, m_bit;
  int m_pc, m_dc, m_bc;
  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 0; m_r2 <= 0; m_tick <= 0; m_bit <= 0;
      m_pc <= 0; m_dc <= 0; m_bc <= 0;
    end else begin
      m_r1 <= 1'b1;
      m_r2 <= m_r1;
      cyc  <= cyc + 1;
      if (m_r2) begin
        automatic bit pf = pre_en && (m_pc <= 1);
        automatic bit ds = pre_en ? pf : 1'b1;
        automatic bit df = ds && (m_dc <= 1);
        automatic bit bf = df && (m_bc <= 1);
        if (pre_en) m_pc <= pf ? eff4(pre_val) : m_pc - 1;
        if (ds)     m_dc <= df ? eff16(divisor) : m_dc - 1;
        if (df)     m_bc <= bf ? ovs(sample_sel) : m_bc - 1;
        m_tick <= df;
        m_bit  <= bf;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the reference, away from the clock edge
  always @(negedge clk_ref) begin
    if (!done) begin
      check({cur_req, " sample_tick"}, int'(sample_tick), int'(m_tick));
      check({cur_req, " bit_strobe"},  int'(bit_strobe),  int'(m_bit));
    end
  end

  task automatic wait_tick(output int t);
    do @(negedge clk_ref); while (!sample_tick);
    t = cyc;
  endtask
  task automatic wait_bit(output int t);
    do @(negedge clk_ref); while (!bit_strobe);
    t = cyc;
  endtask

  task automatic tick_gap(input string req, input int exp);
    int a, b;
    wait_tick(a);
    wait_tick(b);
    check(req, b - a, exp);
  endtask
  task automatic bit_gap(input string req, input int exp);
    int a, b;
    wait_bit(a);
    wait_bit(b);
    check(req, b - a, exp);
  endtask

  task automatic do_reset();
    @(negedge clk_ref);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_ref);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1;
    void'($urandom(32'd1234));
    rst_n = 1'b0; divisor = 16'd3; pre_en = 1'b0; pre_val = 4'd0; sample_sel = 2'b10;
    // R1: outputs held low in reset
    repeat (4) @(negedge clk_ref) begin
      check("R1 tick in reset", int'(sample_tick), 0);
      check("R1 bit in reset",  int'(bit_strobe), 0);
    end
    // R9: first tick and strobe on third edge after release
    cur_req = "R9";
    rst_n = 1'b1;
    t0 = cyc;
    wait_tick(t1);
    check("R9 first tick edge", t1 - t0, 3);
    check("R9 strobe with first tick", int'(bit_strobe), 1);

    // R2: plain divisor
    cur_req = "R2";
    tick_gap("R2 div3 gap", 3);
    divisor = 16'd7; wait_tick(t0);
    tick_gap("R2 div7 gap", 7);

    // R8: peak rate, F=4, D=1
    cur_req = "R8";
    divisor = 16'd1; sample_sel = 2'b10; wait_tick(t0); wait_tick(t0);
    tick_gap("R8 tick every cycle", 1);
    bit_gap("R8 bit every 4", 4);

    // R3: divisor zero behaves as one
    cur_req = "R3";
    divisor = 16'd0; wait_tick(t0); wait_tick(t0);
    tick_gap("R3 div0 gap", 1);

    // R6: each oversampling code
    cur_req = "R6";
    divisor = 16'd2;
    sample_sel = 2'b01; wait_bit(t0); wait_bit(t0);
    bit_gap("R6 x8 gap", 16);
    sample_sel = 2'b00; wait_bit(t0); wait_bit(t0);
    bit_gap("R6 x16 gap", 32);
    sample_sel = 2'b11; wait_bit(t0); wait_bit(t0);
    bit_gap("R6 x16 alt gap", 32);
    sample_sel = 2'b10;

    // R4: prescaler active
    cur_req = "R4";
    divisor = 16'd5; pre_en = 1'b1; pre_val = 4'd3;
    wait_tick(t0); wait_tick(t0); wait_tick(t0);
    tick_gap("R4 pre3 div5 gap", 15);
    pre_val = 4'd0; wait_tick(t0); wait_tick(t0);
    tick_gap("R4 pre0 gap", 5);

    // R5: prescaler bypassed, value ignored
    cur_req = "R5";
    pre_en = 1'b0; pre_val = 4'd9; wait_tick(t0); wait_tick(t0);
    tick_gap("R5 bypass gap", 5);

    // R7: rewrite divisor mid-interval
    cur_req = "R7";
    divisor = 16'd50; wait_tick(t0); wait_tick(t0);
    repeat (3) @(negedge clk_ref);
    divisor = 16'd2;
    wait_tick(t1);
    check("R7 old interval completes", t1 - t0, 50);
    tick_gap("R7 new interval", 2);

    // R2: largest divisor
    cur_req = "R2";
    divisor = 16'hFFFF; do_reset();
    wait_tick(t0);
    wait_tick(t1);
    check("R2 max divisor gap", t1 - t0, 65535);

    // R7: random settings changed at arbitrary phases
    cur_req = "R7 random";
    for (int seg = 0; seg < 25; seg++) begin
      divisor    = 16'($urandom_range(0, 40));
      pre_en     = 1'($urandom_range(0, 1));
      pre_val    = 4'($urandom_range(0, 15));
      sample_sel = 2'($urandom_range(0, 3));
      repeat ($urandom_range(50, 400)) @(negedge clk_ref);
    end
    finish_run();
  end

endmodule